// File: doc/BRIEF.md
# Pointer-Capable Data Register File

This block is the data-memory store of a small 8-bit controller core. It holds 128 bytes in total. A low RAM region of 112 bytes sits at addresses 0x00 to 0x6F. A window of sixteen byte registers sits at addresses 0xF0 to 0xFF. The instruction decoder reaches every byte through a single-port bus: an address, a write enable, write data and combinational read data. The same address can also take a single-bit set, clear or test, carried out as a read-modify-write within one clock.

Three window slots also serve as the core's address pointers. The alternate index pointer is at 0xFC, the stack pointer at 0xFD and the base index pointer at 0xFE, and all three are driven out continuously. The decoder can ask for a post-increment or post-decrement of any pointer once the pointer has been used. It can also ask for a decrement of any window slot that tests the result for zero. The zero result comes back as a skip flag one cycle later. Slot 0xFF is reserved and is always empty.

Top module: `dmem_ptr_regfile`

## Requirements
- R1: Addresses 0x00-0x6F (low RAM) and 0xF0-0xFE (window) store the last byte written. Any address from 0x70 to 0xEF reads 0x00, and writes to those addresses change nothing.
- R2: The window slot at 0xFC drives `ptr_x`, the slot at 0xFD drives `ptr_sp` and the slot at 0xFE drives `ptr_b`. A bus write to one of these addresses shows on its output after the clock edge. A bus read of the address returns the same value.
- R3: While `rst_n` is low, the stack pointer becomes 0x6F and every other window slot becomes 0x00. This includes `ptr_b` and `ptr_x`.
- R4: A post-increment (`ptr_mod`=1) adds one to the pointer chosen by `ptr_sel` (1=B, 2=X, 3=SP, 0=none). The count wraps from 0xFF to 0x00.
- R5: A post-decrement (`ptr_mod`=2) subtracts one from the chosen pointer. The count wraps from 0x00 to 0xFF. A `ptr_mod` of 0 or 3 leaves the pointer unchanged.
- R6: If a bus write or bit write targets a pointer's address in the same cycle as a post-modify of that pointer, the written value is stored.
- R7: Setting `dsz_en` decrements the window slot `dsz_idx` (slot n is address 0xF0+n), with wrap. `skip_o` goes high for exactly the next cycle only if the result is 0x00. Otherwise `skip_o` stays low.
- R8: Address 0xFF always reads 0x00. Bus writes, bit set/clear and decrement-and-test on slot 15 leave it at 0x00, and a decrement-and-test on slot 15 never raises `skip_o`.
- R9: The `bit_op` input selects the bit operation: 1 sets bit `bit_idx` of the addressed byte, 2 clears it, and 3 tests it. Set and clear leave the other seven bits unchanged. A test drives `bit_val` with the bit's current value and writes nothing. When no test is requested, `bit_val` is 0.
- R10: If `bus_we` and a bit set/clear occur in the same cycle, the `bus_wdata` byte is stored unchanged.
- R11: If a write (bus or bit) and a decrement-and-test target the same slot, the write is stored and `skip_o` stays low. If a decrement-and-test and a post-modify target the same pointer, the decrement is applied.
- R12: A pointer holds its value in any cycle where no write, decrement-and-test or post-modify targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Data-memory byte address |
| bus_we | input | 1 | Write `bus_wdata` to `bus_addr` at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of `bus_addr` |
| bit_op | input | 2 | 0 none, 1 set, 2 clear, 3 test |
| bit_idx | input | 3 | Bit position for `bit_op` |
| bit_val | output | 1 | Tested bit value (0 unless testing) |
| ptr_sel | input | 2 | Pointer to post-modify: 0 none, 1 B, 2 X, 3 SP |
| ptr_mod | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| dsz_en | input | 1 | Decrement window slot and test for zero |
| dsz_idx | input | 4 | Window slot for `dsz_en` |
| skip_o | output | 1 | Previous decrement-and-test reached zero |
| ptr_b | output | 8 | Base index pointer (0xFE) |
| ptr_x | output | 8 | Alternate index pointer (0xFC) |
| ptr_sp | output | 8 | Stack pointer (0xFD) |

## Verification
The bench focuses on the edges of the address map and of each pointer's count. It writes and reads back every mapped byte, and it confirms that the unmapped gap and 0xFF read zero. A decoder that folded the gap onto RAM would return stale data there. It drives pointers across 0xFF/0x00 in both directions, where an adder with an extra carry bit or a missing wrap would show up. It sweeps decrement-and-test over every slot at the values 1 and 0, so a skip that was off by one cycle or asserted on 0xFF would be seen. It also pits every pair of write sources against each other, so a reversed priority would store the wrong byte. Bit set, clear and test are swept over all eight positions, so a shifted bit index would be caught.

// File: rtl/ptr_rf_pkg.sv
package ptr_rf_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PSEL_NONE = 2'd0,
    PSEL_B    = 2'd1,
    PSEL_X    = 2'd2,
    PSEL_SP   = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    PMOD_NONE = 2'd0,
    PMOD_INC  = 2'd1,
    PMOD_DEC  = 2'd2,
    PMOD_RSV  = 2'd3
  } pmod_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_TEST = 2'd3
  } bop_e;

  // modulo-256 step of a pointer
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] v,
                                                 input logic [1:0] mode);
    logic [BYTE_W-1:0] r;
    case (mode)
      PMOD_INC: r = v + BYTE_W'(1);
      PMOD_DEC: r = v - BYTE_W'(1);
      default:  r = v;
    endcase
    return r;
  endfunction

  // replace one bit of a byte
  function automatic logic [BYTE_W-1:0] bit_put(input logic [BYTE_W-1:0] v,
                                                input logic [2:0] idx,
                                                input logic val);
    logic [BYTE_W-1:0] r;
    r = v;
    r[idx] = val;
    return r;
  endfunction

  // whether the pointer select maps to a given window slot
  function automatic logic sel_hits(input logic [1:0] sel, input int slot,
                                    input int b_slot, input int x_slot,
                                    input int sp_slot);
    logic r;
    case (sel)
      PSEL_B:  r = (slot == b_slot);
      PSEL_X:  r = (slot == x_slot);
      PSEL_SP: r = (slot == sp_slot);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ptrrf_addr_dec.sv
module ptrrf_addr_dec #(
  parameter int unsigned AW        = 8,
  parameter int unsigned LOW_BYTES = 112,
  parameter int unsigned WIN_BASE  = 240,
  parameter int unsigned WIN_SLOTS = 16,
  parameter int unsigned RSV_SLOT  = 15,
  localparam int unsigned LOW_IW   = $clog2(LOW_BYTES),
  localparam int unsigned WIN_IW   = $clog2(WIN_SLOTS)
) (
  input  logic [AW-1:0]     addr,
  output logic              low_hit,
  output logic [LOW_IW-1:0] low_idx,
  output logic              win_hit,
  output logic              rsv_hit,
  output logic [WIN_IW-1:0] win_idx
);

  logic        in_win;
  int unsigned a_int;

  always_comb begin
    a_int   = int'(addr);
    low_hit = (a_int < LOW_BYTES);
    low_idx = addr[LOW_IW-1:0];
    in_win  = (a_int >= WIN_BASE) && (a_int < WIN_BASE + WIN_SLOTS);
    win_idx = WIN_IW'(a_int - WIN_BASE);
    rsv_hit = in_win && (int'(win_idx) == RSV_SLOT);
    win_hit = in_win && !rsv_hit;
  end

endmodule

// File: rtl/ptrrf_low_ram.sv
module ptrrf_low_ram #(
  parameter int unsigned DW        = 8,
  parameter int unsigned LOW_BYTES = 112,
  localparam int unsigned LOW_IW   = $clog2(LOW_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LOW_IW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  logic [DW-1:0] mem [LOW_BYTES];

  always_ff @(posedge clk) begin
    if (we && int'(idx) < LOW_BYTES) mem[idx] <= wdata;
  end

  assign rdata = (int'(idx) < LOW_BYTES) ? mem[idx] : '0;

endmodule

// File: rtl/ptrrf_window.sv
module ptrrf_window
  import ptr_rf_pkg::*;
#(
  parameter int unsigned WIN_SLOTS = 16,
  parameter int unsigned RSV_SLOT  = 15,
  parameter int unsigned X_SLOT    = 12,
  parameter int unsigned SP_SLOT   = 13,
  parameter int unsigned B_SLOT    = 14,
  parameter logic [7:0]  SP_RESET  = 8'h6F,
  localparam int unsigned WIN_IW   = $clog2(WIN_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIN_IW-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [WIN_IW-1:0] rd_idx,
  output logic [7:0]        rd_data,
  input  logic              dsz_en,
  input  logic [WIN_IW-1:0] dsz_idx,
  output logic [7:0]        dsz_cur,
  output logic              dsz_fire,
  input  logic [1:0]        ptr_sel,
  input  logic [1:0]        ptr_mod,
  output logic [7:0]        ptr_b,
  output logic [7:0]        ptr_x,
  output logic [7:0]        ptr_sp
);

  logic [WIN_SLOTS-1:0][7:0] slot_q;

  // a decrement that is not overridden by a write to the same slot
  assign dsz_fire = dsz_en && (int'(dsz_idx) != RSV_SLOT)
                    && !(wr_en && (wr_idx == dsz_idx));
  assign dsz_cur  = slot_q[dsz_idx];
  assign rd_data  = slot_q[rd_idx];

  for (genvar g = 0; g < WIN_SLOTS; g++) begin : g_slot
    if (g == RSV_SLOT) begin : g_rsv
      assign slot_q[g] = '0;
    end else begin : g_reg
      localparam logic [7:0] RST_VAL = (g == SP_SLOT) ? SP_RESET : 8'h00;
      logic [7:0] q;
      logic       wr_hit, dsz_hit, mod_hit;
      assign wr_hit  = wr_en && (int'(wr_idx) == g);
      assign dsz_hit = dsz_en && (int'(dsz_idx) == g);
      assign mod_hit = sel_hits(ptr_sel, g, B_SLOT, X_SLOT, SP_SLOT)
                       && (ptr_mod == PMOD_INC || ptr_mod == PMOD_DEC);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RST_VAL;
        else if (wr_hit)  q <= wr_data;
        else if (dsz_hit) q <= q - 8'd1;
        else if (mod_hit) q <= ptr_step(q, ptr_mod);
      end
      assign slot_q[g] = q;
    end
  end

  assign ptr_b  = slot_q[B_SLOT];
  assign ptr_x  = slot_q[X_SLOT];
  assign ptr_sp = slot_q[SP_SLOT];

endmodule

// File: rtl/dmem_ptr_regfile.sv
module dmem_ptr_regfile
  import ptr_rf_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned LOW_BYTES = 112,
  parameter int unsigned WIN_BASE  = 240,
  parameter int unsigned WIN_SLOTS = 16,
  parameter int unsigned RSV_SLOT  = 15,
  parameter int unsigned X_SLOT    = 12,
  parameter int unsigned SP_SLOT   = 13,
  parameter int unsigned B_SLOT    = 14,
  parameter logic [7:0]  SP_RESET  = 8'h6F,
  localparam int unsigned LOW_IW   = $clog2(LOW_BYTES),
  localparam int unsigned WIN_IW   = $clog2(WIN_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        bit_op,
  input  logic [2:0]        bit_idx,
  output logic              bit_val,
  input  logic [1:0]        ptr_sel,
  input  logic [1:0]        ptr_mod,
  input  logic              dsz_en,
  input  logic [WIN_IW-1:0] dsz_idx,
  output logic              skip_o,
  output logic [7:0]        ptr_b,
  output logic [7:0]        ptr_x,
  output logic [7:0]        ptr_sp
);

  logic              low_hit, win_hit, rsv_hit;
  logic [LOW_IW-1:0] low_idx;
  logic [WIN_IW-1:0] win_idx;
  logic [7:0]        low_rd, win_rd, cur_byte, wr_val;
  logic              bit_wr, wr_en_eff;
  logic [7:0]        dsz_cur;
  logic              dsz_fire;
  logic              skip_q;

  ptrrf_addr_dec #(
    .AW(AW), .LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE),
    .WIN_SLOTS(WIN_SLOTS), .RSV_SLOT(RSV_SLOT)
  ) u_dec (
    .addr(bus_addr), .low_hit(low_hit), .low_idx(low_idx),
    .win_hit(win_hit), .rsv_hit(rsv_hit), .win_idx(win_idx)
  );

  // current byte at the bus address; unmapped and reserved read zero
  always_comb begin
    if (low_hit)      cur_byte = low_rd;
    else if (win_hit) cur_byte = win_rd;
    else              cur_byte = '0;
  end

  assign bit_wr    = (bit_op == BOP_SET) || (bit_op == BOP_CLR);
  assign wr_en_eff = bus_we || bit_wr;
  assign wr_val    = bus_we ? bus_wdata
                            : bit_put(cur_byte, bit_idx, bit_op == BOP_SET);

  ptrrf_low_ram #(.DW(8), .LOW_BYTES(LOW_BYTES)) u_ram (
    .clk(clk), .we(wr_en_eff && low_hit), .idx(low_idx),
    .wdata(wr_val), .rdata(low_rd)
  );

  ptrrf_window #(
    .WIN_SLOTS(WIN_SLOTS), .RSV_SLOT(RSV_SLOT), .X_SLOT(X_SLOT),
    .SP_SLOT(SP_SLOT), .B_SLOT(B_SLOT), .SP_RESET(SP_RESET)
  ) u_win (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_eff && win_hit), .wr_idx(win_idx), .wr_data(wr_val),
    .rd_idx(win_idx), .rd_data(win_rd),
    .dsz_en(dsz_en), .dsz_idx(dsz_idx), .dsz_cur(dsz_cur), .dsz_fire(dsz_fire),
    .ptr_sel(ptr_sel), .ptr_mod(ptr_mod),
    .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= dsz_fire && (dsz_cur == 8'd1);
  end

  assign skip_o    = skip_q;
  assign bus_rdata = cur_byte;
  assign bit_val   = (bit_op == BOP_TEST) && cur_byte[bit_idx];

endmodule

// File: rtl/dmem_ptr_regfile_chk.sv
module dmem_ptr_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [1:0] ptr_sel,
  input logic [1:0] ptr_mod,
  input logic       dsz_en,
  input logic [3:0] dsz_idx,
  input logic       skip_o,
  input logic [7:0] ptr_b,
  input logic [7:0] ptr_x,
  input logic [7:0] ptr_sp,
  input logic       wr_en_eff,
  input logic       dsz_fire,
  input logic [7:0] dsz_cur
);

  logic was_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_rst <= 1'b1;
    else begin
      was_rst <= 1'b0;
      if (was_rst)
        assert_sp_reset_R3: assert (ptr_sp == 8'h6F || wr_en_eff || dsz_en
                                    || ptr_sel != 2'd0);
    end
  end

  logic b_touched, x_touched;
  assign b_touched = (wr_en_eff && bus_addr == 8'hFE) || (dsz_en && dsz_idx == 4'd14);
  assign x_touched = (wr_en_eff && bus_addr == 8'hFC) || (dsz_en && dsz_idx == 4'd12);

  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 8'h70 && bus_addr < 8'hF0) |-> bus_rdata == 8'h00);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'hFF) |-> bus_rdata == 8'h00);

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == 2'd1 && ptr_mod == 2'd1 && !b_touched)
      |=> ptr_b == 8'($past(ptr_b) + 8'd1));

  assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == 2'd2 && ptr_mod == 2'd2 && !x_touched)
      |=> ptr_x == 8'($past(ptr_x) - 8'd1));

  assert_bus_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'hFE) |=> ptr_b == $past(bus_wdata));

  assert_skip_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsz_fire |=> (skip_o == ($past(dsz_cur) == 8'd1)));

  assert_skip_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dsz_fire |=> !skip_o);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_eff && !dsz_en && ptr_sel == 2'd0)
      |=> ($stable(ptr_b) && $stable(ptr_x) && $stable(ptr_sp)));

endmodule

bind dmem_ptr_regfile dmem_ptr_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_sel(ptr_sel),
  .ptr_mod(ptr_mod), .dsz_en(dsz_en), .dsz_idx(dsz_idx), .skip_o(skip_o),
  .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp), .wr_en_eff(wr_en_eff),
  .dsz_fire(dsz_fire), .dsz_cur(dsz_cur)
);

// File: tb/dmem_ptr_regfile_tb.sv
module dmem_ptr_regfile_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] bit_op = '0;
  logic [2:0] bit_idx = '0;
  logic       bit_val;
  logic [1:0] ptr_sel = '0;
  logic [1:0] ptr_mod = '0;
  logic       dsz_en = 1'b0;
  logic [3:0] dsz_idx = '0;
  logic       skip_o;
  logic [7:0] ptr_b, ptr_x, ptr_sp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  dmem_ptr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_op(bit_op),
    .bit_idx(bit_idx), .bit_val(bit_val), .ptr_sel(ptr_sel), .ptr_mod(ptr_mod),
    .dsz_en(dsz_en), .dsz_idx(dsz_idx), .skip_o(skip_o),
    .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    bus_we = 1'b0; bit_op = 2'd0; ptr_sel = 2'd0; ptr_mod = 2'd0; dsz_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    tick();
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pmod(input logic [1:0] sel, input logic [1:0] m);
    ptr_sel = sel; ptr_mod = m;
    tick();
    idle();
  endtask

  task automatic dsz(input logic [3:0] i);
    dsz_en = 1'b1; dsz_idx = i;
    tick();
    idle();
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R3: reset values
    chk("R3 sp reset", ptr_sp, 8'h6F);
    chk("R3 b reset", ptr_b, 8'h00);
    chk("R3 x reset", ptr_x, 8'h00);
    for (int i = 0; i < 15; i++) begin
      rd(8'(8'hF0 + i), v);
      chk("R3 window reset", v, (i == 13) ? 8'h6F : 8'h00);
    end

    // R1: fill and read back all mapped bytes
    for (int a = 0; a < 8'h70; a++) wr(8'(a), pat(a));
    for (int a = 8'hF0; a < 8'hFF; a++) wr(8'(a), pat(a));
    for (int a = 8'h70; a < 8'hF0; a++) wr(8'(a), 8'hA5);
    for (int a = 0; a < 8'h70; a++) begin rd(8'(a), v); chk("R1 low ram", v, pat(a)); end
    for (int a = 8'hF0; a < 8'hFF; a++) begin rd(8'(a), v); chk("R1 window", v, pat(a)); end
    for (int a = 8'h70; a < 8'hF0; a++) begin rd(8'(a), v); chk("R1 unmapped", v, 8'h00); end

    // R2: pointer mapping
    chk("R2 x map", ptr_x, pat(8'hFC));
    chk("R2 sp map", ptr_sp, pat(8'hFD));
    chk("R2 b map", ptr_b, pat(8'hFE));
    wr(8'hFE, 8'h3C); chk("R2 b write", ptr_b, 8'h3C);
    rd(8'hFE, v); chk("R2 b read", v, 8'h3C);

    // R8: reserved slot
    wr(8'hFF, 8'h55); rd(8'hFF, v); chk("R8 rsv write", v, 8'h00);
    bus_addr = 8'hFF; bit_op = 2'd1; bit_idx = 3'd3; tick(); idle();
    rd(8'hFF, v); chk("R8 rsv bitset", v, 8'h00);
    dsz(4'd15); chk("R8 rsv dsz skip", 8'(skip_o), 8'h00);
    rd(8'hFF, v); chk("R8 rsv dsz", v, 8'h00);

    // R4/R5: wrap in both directions for every pointer
    for (int s = 1; s < 4; s++) begin
      wr(8'(8'hFB + ((s == 1) ? 3 : (s == 2) ? 1 : 2)), 8'hFE);
      pmod(2'(s), 2'd1);
      v = (s == 1) ? ptr_b : (s == 2) ? ptr_x : ptr_sp; chk("R4 inc", v, 8'hFF);
      pmod(2'(s), 2'd1);
      v = (s == 1) ? ptr_b : (s == 2) ? ptr_x : ptr_sp; chk("R4 wrap", v, 8'h00);
      pmod(2'(s), 2'd2);
      v = (s == 1) ? ptr_b : (s == 2) ? ptr_x : ptr_sp; chk("R5 wrap", v, 8'hFF);
      pmod(2'(s), 2'd2);
      v = (s == 1) ? ptr_b : (s == 2) ? ptr_x : ptr_sp; chk("R5 dec", v, 8'hFE);
      pmod(2'(s), 2'd3);
      v = (s == 1) ? ptr_b : (s == 2) ? ptr_x : ptr_sp; chk("R5 mode3 hold", v, 8'hFE);
    end

    // R6: write beats post-modify
    wr(8'hFE, 8'h20);
    bus_addr = 8'hFE; bus_we = 1'b1; bus_wdata = 8'h77; ptr_sel = 2'd1; ptr_mod = 2'd1;
    tick(); idle();
    chk("R6 bus over inc", ptr_b, 8'h77);
    bus_addr = 8'hFC; bit_op = 2'd1; bit_idx = 3'd7; ptr_sel = 2'd2; ptr_mod = 2'd2;
    wr(8'hFC, 8'h01);
    bus_addr = 8'hFC; bit_op = 2'd1; bit_idx = 3'd7; ptr_sel = 2'd2; ptr_mod = 2'd2;
    tick(); idle();
    chk("R6 bit over dec", ptr_x, 8'h81);

    // R7: decrement-and-test over all slots
    for (int i = 0; i < 15; i++) begin
      wr(8'(8'hF0 + i), 8'h02);
      dsz(4'(i)); chk("R7 no skip at 1", 8'(skip_o), 8'h00);
      dsz(4'(i)); chk("R7 skip at 0", 8'(skip_o), 8'h01);
      rd(8'(8'hF0 + i), v); chk("R7 value zero", v, 8'h00);
      dsz(4'(i)); chk("R7 no skip at ff", 8'(skip_o), 8'h00);
      rd(8'(8'hF0 + i), v); chk("R7 wrap ff", v, 8'hFF);
    end
    wr(8'hF3, 8'h01);
    dsz(4'd3); chk("R7 skip pulse", 8'(skip_o), 8'h01);
    tick(); chk("R7 skip one cycle", 8'(skip_o), 8'h00);

    // R11: priority between sources
    wr(8'hF5, 8'h01);
    bus_addr = 8'hF5; bus_we = 1'b1; bus_wdata = 8'h40; dsz_en = 1'b1; dsz_idx = 4'd5;
    tick(); idle();
    chk("R11 write over dsz skip", 8'(skip_o), 8'h00);
    rd(8'hF5, v); chk("R11 write over dsz", v, 8'h40);
    wr(8'hFE, 8'h10);
    dsz_en = 1'b1; dsz_idx = 4'd14; ptr_sel = 2'd1; ptr_mod = 2'd1;
    tick(); idle();
    chk("R11 dsz over inc", ptr_b, 8'h0F);

    // R9: bit set/clear/test sweep
    for (int k = 0; k < 8; k++) begin
      wr(8'h10, 8'h00);
      bus_addr = 8'h10; bit_op = 2'd1; bit_idx = 3'(k); tick(); idle();
      rd(8'h10, v); chk("R9 set", v, 8'(1 << k));
      bit_op = 2'd3; bit_idx = 3'(k); #1; chk("R9 test one", 8'(bit_val), 8'h01);
      bit_idx = 3'((k + 1) % 8); #1; chk("R9 test zero", 8'(bit_val), 8'h00);
      bit_op = 2'd0; #1; chk("R9 no test", 8'(bit_val), 8'h00);
      wr(8'hF2, 8'hFF);
      bus_addr = 8'hF2; bit_op = 2'd2; bit_idx = 3'(k); tick(); idle();
      rd(8'hF2, v); chk("R9 clear", v, 8'(~(1 << k)));
    end
    wr(8'h20, 8'h5A);
    bus_addr = 8'h20; bit_op = 2'd3; bit_idx = 3'd0; tick(); idle();
    rd(8'h20, v); chk("R9 test no write", v, 8'h5A);

    // R10: bus write beats bit op
    bus_addr = 8'h21; bus_we = 1'b1; bus_wdata = 8'h00; bit_op = 2'd1; bit_idx = 3'd2;
    tick(); idle();
    rd(8'h21, v); chk("R10 bus over bit", v, 8'h00);

    // R12: idle hold
    wr(8'hFC, 8'h11); wr(8'hFD, 8'h22); wr(8'hFE, 8'h33);
    repeat (4) tick();
    chk("R12 hold x", ptr_x, 8'h11);
    chk("R12 hold sp", ptr_sp, 8'h22);
    chk("R12 hold b", ptr_b, 8'h33);
    pmod(2'd1, 2'd1);
    chk("R12 x untouched", ptr_x, 8'h11);
    chk("R12 sp untouched", ptr_sp, 8'h22);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule